// File: doc/BRIEF.md
# 8-bit interval and PWM timer

An 8-bit up-counter shares a single equality comparator between two operating modes. In interval mode the counter returns to zero whenever it equals the compare register, and each such match emits a one-cycle interrupt pulse. The result is a periodic tick every (compare + 1) count clocks. In PWM mode the counter runs freely through its full 256-state range. The timer output goes to its active level when the counter wraps and returns to inactive when the counter reaches the compare value. The match interrupt stays silent in this mode.

Counting is paced by a count-enable strobe from an external prescaler and gated by a run input. Software reaches the compare and control registers through a flat write/read port. The block protects two usage rules in hardware. In interval mode it drops compare writes while running. In PWM mode it raises a sticky error flag when compare writes come too close together. In PWM mode a newly written compare value takes effect only at the next wrap, so each period has one consistent duty.

Top module: `tmr8_cmp_pwm`

## Requirements
- R1: After reset the compare register and the control register both read 00h, `irq_o` is 0 and `tout_o` is 0.
- R2: A write with `wr_sel_i`=0 targets the compare register and a write with `wr_sel_i`=1 targets the control register. `rd_sel_i` uses the same selector encoding. In the control word, bit 0 selects PWM mode when 1, bit 1 inverts the output (active-low) when 1, and bit 7 reads back the sticky error flag. Writing bit 7 as 1 clears the flag.
- R3: The counter advances only on clock edges where both `tick_i` and `run_i` are high. It is held at 00h while `run_i` is low.
- R4: In interval mode, a count tick that finds the counter equal to the compare value returns the counter to 00h, so matches recur every (compare + 1) ticks.
- R5: `irq_o` goes high for exactly one clock, in the cycle after the edge of an interval-mode matching tick. It never goes high in PWM mode.
- R6: In interval mode, compare-register writes that arrive while `run_i` is high are ignored.
- R7: In PWM mode the counter wraps from FFh to 00h. The output becomes active at the wrap and inactive on the tick that brings the counter to the compare value, so it is active for exactly `compare` of every 256 ticks.
- R8: In PWM mode the compare value used for the output is captured from the register at each wrap. A write in the middle of a period changes only the following period.
- R9: A compare value of 00h in PWM mode keeps the output inactive for the whole period.
- R10: The output sits at its inactive level (0, or 1 when inverted) while `run_i` is low and in interval mode.
- R11: In PWM mode with `run_i` high, a compare write made before 3 count ticks have passed since the previous accepted compare write sets the sticky error flag. The write itself still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 compare, 1 control |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 1 | Read target: 0 compare, 1 control |
| rd_data_o | output | 8 | Read data for the selected register |
| tick_i | input | 1 | Count-clock enable from the prescaler |
| run_i | input | 1 | Timer run enable |
| irq_o | output | 1 | Interval-mode match pulse |
| tout_o | output | 1 | Timer output |

## Verification
The properties assume that `tick_i`, `run_i` and the write port are synchronous, single-cycle qualified strobes. They also assume that the mode bit is changed only while `run_i` is low, because a mode change while running is not covered. The bench changes the control register only after dropping `run_i`. It holds `tick_i` high continuously for the duty measurements and pulses it on alternate cycles for the gating check. For compare writes it uses the single-cycle write task, plus a single inline strobe for the mid-period write.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
    localparam int unsigned TMR_W    = 8;
    localparam int unsigned WR_GAP   = 3;
    localparam logic        SEL_CMP  = 1'b0;
    localparam logic        SEL_CTL  = 1'b1;
    localparam int unsigned CTL_MODE = 0;
    localparam int unsigned CTL_INV  = 1;
endpackage

// File: rtl/tmr8_regs.sv
module tmr8_regs
    import tmr8_pkg::*;
#(
    parameter int unsigned W       = TMR_W,
    parameter int unsigned GAP_MIN = WR_GAP
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wr_en_i,
    input  logic         wr_sel_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         rd_sel_i,
    output logic [W-1:0] rd_data_o,
    input  logic         run_i,
    input  logic         tick_i,
    output logic [W-1:0] cmp_o,
    output logic         mode_o,
    output logic         inv_o,
    output logic         err_o
);
    localparam int unsigned GW      = $clog2(GAP_MIN + 1);
    localparam logic [GW-1:0] GAP_LIM = GW'(GAP_MIN);
    localparam int unsigned ERR_BIT = W - 1;

    typedef struct packed {
        logic [W-1:0]  cmp;
        logic          mode;
        logic          inv;
        logic          err;
        logic [GW-1:0] gap;
    } regs_t;

    regs_t r_d, r_q;
    logic  cmp_wr, ctl_wr, cmp_lock, too_soon;

    always_comb begin
        r_d      = r_q;
        cmp_wr   = wr_en_i && (wr_sel_i == SEL_CMP);
        ctl_wr   = wr_en_i && (wr_sel_i == SEL_CTL);
        cmp_lock = run_i && !r_q.mode;
        too_soon = run_i && r_q.mode && (r_q.gap != GAP_LIM);

        if (tick_i && (r_q.gap != GAP_LIM)) begin
            r_d.gap = r_q.gap + 1'b1;
        end
        if (cmp_wr && !cmp_lock) begin
            r_d.cmp = wr_data_i;
            r_d.gap = '0;
            if (too_soon) begin
                r_d.err = 1'b1;
            end
        end
        if (ctl_wr) begin
            r_d.mode = wr_data_i[CTL_MODE];
            r_d.inv  = wr_data_i[CTL_INV];
            if (wr_data_i[ERR_BIT]) begin
                r_d.err = 1'b0;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q      <= '0;
            r_q.gap  <= GAP_LIM;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rd_data_o = r_q.cmp;
        if (rd_sel_i == SEL_CTL) begin
            rd_data_o           = '0;
            rd_data_o[CTL_MODE] = r_q.mode;
            rd_data_o[CTL_INV]  = r_q.inv;
            rd_data_o[ERR_BIT]  = r_q.err;
        end
    end

    assign cmp_o  = r_q.cmp;
    assign mode_o = r_q.mode;
    assign inv_o  = r_q.inv;
    assign err_o  = r_q.err;
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
    import tmr8_pkg::*;
#(
    parameter int unsigned W = TMR_W
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         run_i,
    input  logic         tick_i,
    input  logic         mode_i,
    input  logic [W-1:0] cmp_i,
    output logic [W-1:0] cnt_o,
    output logic         irq_o,
    output logic         active_o
);
    localparam logic [W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] duty;
        logic         act;
        logic         irq;
    } core_t;

    core_t c_d, c_q;
    logic [W-1:0] cnt_inc;

    always_comb begin
        c_d     = c_q;
        c_d.irq = 1'b0;
        cnt_inc = c_q.cnt + 1'b1;

        if (!run_i) begin
            c_d.cnt  = '0;
            c_d.act  = 1'b0;
            c_d.duty = cmp_i;
        end else if (tick_i) begin
            if (!mode_i) begin
                c_d.act = 1'b0;
                if (c_q.cnt == cmp_i) begin
                    c_d.cnt = '0;
                    c_d.irq = 1'b1;
                end else begin
                    c_d.cnt = cnt_inc;
                end
            end else begin
                c_d.cnt = cnt_inc;
                if (c_q.cnt == CNT_MAX) begin
                    c_d.duty = cmp_i;
                    c_d.act  = (cmp_i != '0);
                end else if (cnt_inc == c_q.duty) begin
                    c_d.act = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cnt_o    = c_q.cnt;
    assign irq_o    = c_q.irq;
    assign active_o = c_q.act;
endmodule

// File: rtl/tmr8_cmp_pwm.sv
module tmr8_cmp_pwm
    import tmr8_pkg::*;
#(
    parameter int unsigned W       = TMR_W,
    parameter int unsigned GAP_MIN = WR_GAP
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         wr_en_i,
    input  logic         wr_sel_i,
    input  logic [W-1:0] wr_data_i,
    input  logic         rd_sel_i,
    output logic [W-1:0] rd_data_o,
    input  logic         tick_i,
    input  logic         run_i,
    output logic         irq_o,
    output logic         tout_o
);
    logic [W-1:0] cmp_w;
    logic [W-1:0] cnt_w;
    logic         mode_w, inv_w, err_w, act_w;

    tmr8_regs #(.W(W), .GAP_MIN(GAP_MIN)) regs_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .rd_sel_i  (rd_sel_i),
        .rd_data_o (rd_data_o),
        .run_i     (run_i),
        .tick_i    (tick_i),
        .cmp_o     (cmp_w),
        .mode_o    (mode_w),
        .inv_o     (inv_w),
        .err_o     (err_w)
    );

    tmr8_core #(.W(W)) core_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (run_i),
        .tick_i   (tick_i),
        .mode_i   (mode_w),
        .cmp_i    (cmp_w),
        .cnt_o    (cnt_w),
        .irq_o    (irq_o),
        .active_o (act_w)
    );

    assign tout_o = act_w ^ inv_w;
endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk
    import tmr8_pkg::*;
#(
    parameter int unsigned W = TMR_W
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic         wr_en_i,
    input logic         wr_sel_i,
    input logic [W-1:0] wr_data_i,
    input logic         tick_i,
    input logic         run_i,
    input logic         irq_i,
    input logic         tout_i,
    input logic [W-1:0] cnt_i,
    input logic [W-1:0] cmp_i,
    input logic         mode_i,
    input logic         inv_i,
    input logic         err_i
);
    // R3
    cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !tick_i) |=> $stable(cnt_i));

    // R3
    cnt_stopped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (cnt_i == '0));

    // R5
    irq_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i |-> $past(tick_i && run_i));

    // R5
    irq_pwm_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_i |=> !irq_i);

    // R6
    cmp_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && (wr_sel_i == SEL_CMP) && run_i && !mode_i) |=> $stable(cmp_i));

    // R10
    tout_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (tout_i == inv_i));

    // R11
    err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_i && !(wr_en_i && (wr_sel_i == SEL_CTL) && wr_data_i[W-1])) |=> err_i);
endmodule

bind tmr8_cmp_pwm tmr8_chk #(.W(W)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .tick_i    (tick_i),
    .run_i     (run_i),
    .irq_i     (irq_o),
    .tout_i    (tout_o),
    .cnt_i     (cnt_w),
    .cmp_i     (cmp_w),
    .mode_i    (mode_w),
    .inv_i     (inv_w),
    .err_i     (err_w)
);

// File: tb/tmr8_cmp_pwm_tb_top.sv
module tmr8_cmp_pwm_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en, wr_sel, rd_sel, tick, run;
    logic [7:0] wr_data, rd_data;
    logic       irq, tout;

    int n_chk  = 0;
    int n_fail = 0;
    int irq_seen = 0;

    always #5 clk = ~clk;

    tmr8_cmp_pwm dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_sel_i  (wr_sel),
        .wr_data_i (wr_data),
        .rd_sel_i  (rd_sel),
        .rd_data_o (rd_data),
        .tick_i    (tick),
        .run_i     (run),
        .irq_o     (irq),
        .tout_o    (tout)
    );

    // duty table: {compare value, expected active ticks per 256}
    localparam logic [15:0] DUTY_VEC [6] = '{
        {8'h00, 8'd0}, {8'h01, 8'd1}, {8'h40, 8'd64},
        {8'h80, 8'd128}, {8'hFE, 8'd254}, {8'hFF, 8'd255}
    };

    always @(negedge clk) if (irq) irq_seen++;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        wr_sel = sel; wr_data = d; wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pwm_start(input logic [7:0] c, input logic [7:0] ctl);
        run = 1'b0; tick = 1'b0;
        step();
        wr(1'b0, c);
        wr(1'b1, ctl);
        run = 1'b1; tick = 1'b1;
        repeat (256) step();
    endtask

    task automatic count_active(input bit lvl, output int n);
        n = 0;
        for (int i = 0; i < 256; i++) begin
            if (tout == lvl) n++;
            step();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
        rd_sel = 1'b0; tick = 1'b0; run = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        rd(1'b0, v); check(v == 8'h00, "R1 cmp", v, 0);
        rd(1'b1, v); check(v == 8'h00, "R1 ctl", v, 0);
        check(tout == 1'b0, "R1 tout", tout, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);

        // R2 register access
        wr(1'b0, 8'h5A); rd(1'b0, v); check(v == 8'h5A, "R2 cmp", v, 8'h5A);
        wr(1'b1, 8'h03); rd(1'b1, v); check(v == 8'h03, "R2 ctl", v, 3);

        // R3 stopped counter ignores ticks
        wr(1'b1, 8'h00); wr(1'b0, 8'h03);
        tick = 1'b1; irq_seen = 0;
        repeat (10) step();
        check(irq_seen == 0, "R3 stopped", irq_seen, 0);

        // R4 R5 interval period compare+1 with single pulses
        run = 1'b1;
        for (int i = 1; i <= 8; i++) begin
            step();
            check(irq == ((i % 4) == 0), "R4 R5 interval", irq, (i % 4) == 0);
        end

        // R6 compare write ignored while running in interval mode
        wr(1'b0, 8'h09); rd(1'b0, v); check(v == 8'h03, "R6 locked", v, 3);

        // R3 gated ticks: match after 4 ticks on alternate cycles
        run = 1'b0; tick = 1'b0; step(); run = 1'b1;
        for (int i = 1; i <= 8; i++) begin
            tick = i[0];
            step();
            check(irq == (i == 7), "R3 gating", irq, i == 7);
        end
        tick = 1'b0;

        // R7 R9 R5 duty table in PWM mode
        foreach (DUTY_VEC[k]) begin
            pwm_start(DUTY_VEC[k][15:8], 8'h01);
            irq_seen = 0;
            count_active(1'b1, n);
            check(n == int'(DUTY_VEC[k][7:0]), "R7 R9 duty", n, DUTY_VEC[k][7:0]);
            check(irq_seen == 0, "R5 pwm no irq", irq_seen, 0);
        end

        // R8 mid-period write applies at the next wrap
        pwm_start(8'h40, 8'h01);
        n = 0;
        for (int i = 0; i < 256; i++) begin
            if (tout) n++;
            if (i == 10) begin wr_sel = 1'b0; wr_data = 8'h80; wr_en = 1'b1; end
            step();
            wr_en = 1'b0;
        end
        check(n == 64, "R8 current period", n, 64);
        count_active(1'b1, n);
        check(n == 128, "R8 next period", n, 128);
        rd(1'b1, v); check(v == 8'h01, "R11 no err", v, 1);

        // R11 write spacing
        wr(1'b0, 8'h80); repeat (3) step(); wr(1'b0, 8'h80);
        rd(1'b1, v); check(v == 8'h01, "R11 spaced ok", v, 1);
        wr(1'b0, 8'h80); wr(1'b0, 8'h70);
        rd(1'b1, v); check(v == 8'h81, "R11 err set", v, 8'h81);
        rd(1'b0, v); check(v == 8'h70, "R11 write kept", v, 8'h70);
        repeat (5) step();
        rd(1'b1, v); check(v == 8'h81, "R11 sticky", v, 8'h81);
        wr(1'b1, 8'h81);
        rd(1'b1, v); check(v == 8'h01, "R2 err clear", v, 1);

        // R10 inverted idle and inverted zero duty
        run = 1'b0; tick = 1'b0; step();
        wr(1'b1, 8'h02); step();
        check(tout == 1'b1, "R10 inv idle", tout, 1);
        pwm_start(8'h00, 8'h03);
        count_active(1'b1, n);
        check(n == 256, "R10 R9 inv zero duty", n, 256);
        pwm_start(8'h40, 8'h03);
        count_active(1'b0, n);
        check(n == 64, "R10 inv duty", n, 64);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule